// File: doc/BRIEF.md
# Barrel Shifter with Carry Rotate

A 32-bit shift unit for a processor datapath. Each operation takes one operand, an
8-bit shift amount, a flag that says whether the amount came from an immediate field
or from a register, a 4-bit subclass code and the current carry flag. It returns the
shifted word and the carry-out produced by the shift. The unit supports logical shifts
left and right, an arithmetic shift right, a plain 32-bit rotate right, and a one-place
rotate through a 33rd bit held in the carry flag.

The carry rotate can be selected in two ways. It has its own subclass code. A plain
rotate with an immediate amount of zero also becomes the carry rotate. Subclass codes
that are not defined leave the operand and the carry unchanged and raise an illegal-op
output. The shift itself is a single logarithmic funnel network that all operations
share. An optional output register, enabled by default, adds one cycle of latency.

Top module: `rot_shift_unit`

## Requirements
- R1: Subclass encoding: 4'b0000 shifts left logically, 4'b0001 shifts right logically, 4'b0010 shifts right arithmetically, 4'b0011 rotates right, 4'b0100 rotates right through carry. `amt_imm`=1 marks the amount as an immediate.
- R2: Shift left by n in 1..31 fills with zeros, and carry-out is operand bit 32-n.
- R3: Logical shift right by n in 1..31 fills with zeros, and carry-out is operand bit n-1.
- R4: Arithmetic shift right by n in 1..31 fills with operand bit 31, and carry-out is operand bit n-1.
- R5: Rotate right by a nonzero amount rotates by the amount modulo 32, and carry-out equals result bit 31.
- R6: Subclass 4'b0100 gives {carry_in, operand[31:1]} with carry-out operand[0], for any amount and any amount source.
- R7: Subclass 4'b0011 with `amt_imm`=1 and amount 0 performs the R6 carry rotate. With `amt_imm`=0 and amount 0 it does not.
- R8: Amount 0 on a left shift, a right shift or a register-sourced rotate returns the operand unchanged, with carry-out equal to carry_in.
- R9: Logical shifts by exactly 32 give 0 with carry-out operand[0] (left) or operand[31] (right). Amounts above 32 give 0 with carry-out 0.
- R10: Arithmetic shift right by 32 or more fills every result bit with operand bit 31, and carry-out equals that bit.
- R11: Subclass codes 4'b0101 to 4'b1111 return the operand and carry_in unchanged, with `illegal`=1. Every defined code gives `illegal`=0.
- R12: With the output register on, the outputs show the result for the inputs presented one rising edge earlier. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| operand | input | 32 | Word to be shifted |
| amt | input | 8 | Shift amount |
| amt_imm | input | 1 | 1: amount comes from an immediate field |
| subcls | input | 4 | Shift subclass code |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Shifter carry-out |
| illegal | output | 1 | Reserved subclass code seen |

## Verification
Two functions meet in one cycle: the plain rotate and the carry rotate. Both are reached through subclass 4'b0011, and only the amount source together with a zero amount chooses between them. The bench applies code 4'b0011 with amount 0 back to back, once with the immediate flag set and once clear. It also sets amounts that are multiples of 32 from a register, which must still behave as a plain rotate. Each outcome is compared against a bench model that shifts one position at a time. Random stimulus also mixes in the dedicated carry-rotate code with nonzero amounts, to show that the amount is ignored there.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // Subclass codes seen on the subcls input
    typedef enum logic [3:0] {
        SC_LSL = 4'b0000,
        SC_LSR = 4'b0001,
        SC_ASR = 4'b0010,
        SC_ROR = 4'b0011,
        SC_RRC = 4'b0100
    } subcls_e;

    // Internal operation kinds after decode
    typedef enum logic [2:0] {
        K_PASS = 3'd0,
        K_LSL  = 3'd1,
        K_LSR  = 3'd2,
        K_ASR  = 3'd3,
        K_ROR  = 3'd4,
        K_RRC  = 3'd5
    } op_kind_e;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
#(
    parameter int AMT_W = 8
) (
    input  logic [3:0]       subcls,
    input  logic [AMT_W-1:0] amt,
    input  logic             amt_imm,
    output op_kind_e         kind,
    output logic             reserved
);

    logic amt_zero;

    always_comb begin
        amt_zero = (amt == '0);
        reserved = 1'b0;
        kind     = K_PASS;
        unique case (subcls)
            SC_LSL: kind = amt_zero ? K_PASS : K_LSL;
            SC_LSR: kind = amt_zero ? K_PASS : K_LSR;
            SC_ASR: kind = amt_zero ? K_PASS : K_ASR;
            SC_ROR: begin
                if (amt_zero && amt_imm) begin
                    kind = K_RRC;
                end else if (amt_zero) begin
                    kind = K_PASS;
                end else begin
                    kind = K_ROR;
                end
            end
            SC_RRC: kind = K_RRC;
            default: begin
                kind     = K_PASS;
                reserved = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/shf_funnel.sv
module shf_funnel #(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    hi,
    input  logic [W-1:0]    lo,
    input  logic [SH_W-1:0] sh,
    output logic [W-1:0]    dout
);

    localparam int FW = 2 * W;

    logic [FW-1:0] stage [0:SH_W];

    assign stage[0] = {hi, lo};

    genvar k;
    generate
        for (k = 0; k < SH_W; k++) begin : g_stage
            assign stage[k+1] = sh[k] ? (stage[k] >> (1 << k)) : stage[k];
        end
    endgenerate

    assign dout = stage[SH_W][W-1:0];

endmodule

// File: rtl/rot_shift_unit.sv
module rot_shift_unit
    import shf_pkg::*;
#(
    parameter int W       = 32,
    parameter int AMT_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     operand,
    input  logic [AMT_W-1:0] amt,
    input  logic             amt_imm,
    input  logic [3:0]       subcls,
    input  logic             carry_in,
    output logic [W-1:0]     result,
    output logic             carry_out,
    output logic             illegal
);

    localparam int SH_W = $clog2(W);
    localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(W);

    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
        logic         ill;
    } shf_out_t;

    op_kind_e        kind;
    logic            reserved;
    logic [W-1:0]    fun_hi;
    logic [W-1:0]    fun_lo;
    logic [SH_W-1:0] fun_sh;
    logic [W-1:0]    fun_out;
    logic [SH_W-1:0] amt_low;
    logic [SH_W-1:0] lsl_sh;
    logic            sign;
    shf_out_t        nxt_d;
    shf_out_t        nxt_q;

    shf_decode #(.AMT_W(AMT_W)) i_decode (
        .subcls   (subcls),
        .amt      (amt),
        .amt_imm  (amt_imm),
        .kind     (kind),
        .reserved (reserved)
    );

    // Funnel input selection
    always_comb begin
        amt_low = amt[SH_W-1:0];
        lsl_sh  = SH_W'(0) - amt_low;
        sign    = operand[W-1];
        fun_hi  = operand;
        fun_lo  = operand;
        fun_sh  = amt_low;
        unique case (kind)
            K_LSL: begin
                fun_hi = operand;
                fun_lo = '0;
                fun_sh = lsl_sh;
            end
            K_LSR: begin
                fun_hi = '0;
                fun_lo = operand;
            end
            K_ASR: begin
                fun_hi = {W{sign}};
                fun_lo = operand;
            end
            default: begin
                fun_hi = operand;
                fun_lo = operand;
            end
        endcase
    end

    shf_funnel #(.W(W), .SH_W(SH_W)) i_funnel (
        .hi   (fun_hi),
        .lo   (fun_lo),
        .sh   (fun_sh),
        .dout (fun_out)
    );

    // Next-value computation
    always_comb begin
        nxt_d.res = operand;
        nxt_d.cy  = carry_in;
        nxt_d.ill = reserved;
        unique case (kind)
            K_LSL: begin
                if (amt < AMT_FULL) begin
                    nxt_d.res = fun_out;
                    nxt_d.cy  = operand[lsl_sh];
                end else if (amt == AMT_FULL) begin
                    nxt_d.res = '0;
                    nxt_d.cy  = operand[0];
                end else begin
                    nxt_d.res = '0;
                    nxt_d.cy  = 1'b0;
                end
            end
            K_LSR: begin
                if (amt < AMT_FULL) begin
                    nxt_d.res = fun_out;
                    nxt_d.cy  = operand[amt_low - SH_W'(1)];
                end else if (amt == AMT_FULL) begin
                    nxt_d.res = '0;
                    nxt_d.cy  = operand[W-1];
                end else begin
                    nxt_d.res = '0;
                    nxt_d.cy  = 1'b0;
                end
            end
            K_ASR: begin
                if (amt < AMT_FULL) begin
                    nxt_d.res = fun_out;
                    nxt_d.cy  = operand[amt_low - SH_W'(1)];
                end else begin
                    nxt_d.res = {W{sign}};
                    nxt_d.cy  = sign;
                end
            end
            K_ROR: begin
                nxt_d.res = fun_out;
                nxt_d.cy  = fun_out[W-1];
            end
            K_RRC: begin
                nxt_d.res = {carry_in, operand[W-1:1]};
                nxt_d.cy  = operand[0];
            end
            default: begin
                nxt_d.res = operand;
                nxt_d.cy  = carry_in;
            end
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    nxt_q <= '0;
                end else begin
                    nxt_q <= nxt_d;
                end
            end
        end else begin : g_comb
            assign nxt_q = nxt_d;
        end
    endgenerate

    assign result    = nxt_q.res;
    assign carry_out = nxt_q.cy;
    assign illegal   = nxt_q.ill;

endmodule

// File: rtl/rot_shift_unit_chk.sv
module rot_shift_unit_chk #(
    parameter int W       = 32,
    parameter int AMT_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     operand,
    input logic [AMT_W-1:0] amt,
    input logic             amt_imm,
    input logic [3:0]       subcls,
    input logic             carry_in,
    input logic [W-1:0]     result,
    input logic             carry_out,
    input logic             illegal
);

    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
        end
    end

    always_comb begin
        if (!rst_n && REG_OUT) begin
            assert_reset_clear_R12 : assert (result == '0 && !carry_out && !illegal);
        end
    end

    generate
        if (REG_OUT) begin : g_props
            assert_reserved_flag_R11 : assert property (@(posedge clk) disable iff (!rst_n)
                primed |-> (illegal == ($past(subcls) > 4'd4)));

            assert_reserved_pass_R11 : assert property (@(posedge clk) disable iff (!rst_n)
                (primed && illegal) |-> (result == $past(operand) && carry_out == $past(carry_in)));

            assert_carry_rotate_R6 : assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(subcls) == 4'd4) |->
                (result == {$past(carry_in), $past(operand[W-1:1])} && carry_out == $past(operand[0])));

            assert_imm_zero_rotate_R7 : assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(subcls) == 4'd3 && $past(amt) == '0 && $past(amt_imm)) |->
                (result == {$past(carry_in), $past(operand[W-1:1])} && carry_out == $past(operand[0])));

            assert_ror_carry_R5 : assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(subcls) == 4'd3 && $past(amt) != '0) |->
                (carry_out == result[W-1]));

            assert_zero_pass_R8 : assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(subcls) < 4'd4 && $past(amt) == '0 &&
                 !($past(subcls) == 4'd3 && $past(amt_imm))) |->
                (result == $past(operand) && carry_out == $past(carry_in)));

            assert_asr_wide_R10 : assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(subcls) == 4'd2 && $past(amt) >= AMT_W'(W)) |->
                (result == {W{$past(operand[W-1])}} && carry_out == $past(operand[W-1])));
        end
    endgenerate

endmodule

bind rot_shift_unit rot_shift_unit_chk #(.W(W), .AMT_W(AMT_W), .REG_OUT(REG_OUT)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .operand   (operand),
    .amt       (amt),
    .amt_imm   (amt_imm),
    .subcls    (subcls),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .illegal   (illegal)
);

// File: tb/test_rot_shift_unit.sv
module test_rot_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand = '0;
    logic [7:0]  amt = '0;
    logic        amt_imm = 1'b0;
    logic [3:0]  subcls = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        illegal;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rot_shift_unit i_rot_shift_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand   (operand),
        .amt       (amt),
        .amt_imm   (amt_imm),
        .subcls    (subcls),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out),
        .illegal   (illegal)
    );

    // Bit-serial reference: {illegal, carry, result}
    function automatic logic [33:0] model(logic [31:0] x, logic [7:0] n, logic imm,
                                          logic [3:0] sc, logic ci);
        logic [31:0] v = x;
        logic        c = ci;
        logic        bad = 1'b0;
        case (sc)
            4'd0: for (int i = 0; i < int'(n); i++) begin c = v[31]; v = v << 1; end
            4'd1: for (int i = 0; i < int'(n); i++) begin c = v[0]; v = v >> 1; end
            4'd2: for (int i = 0; i < int'(n); i++) begin c = v[0]; v = {v[31], v[31:1]}; end
            4'd3: begin
                if (n == 0 && imm) begin
                    c = x[0]; v = {ci, x[31:1]};
                end else begin
                    for (int i = 0; i < int'(n); i++) begin v = {v[0], v[31:1]}; c = v[31]; end
                end
            end
            4'd4: begin c = x[0]; v = {ci, x[31:1]}; end
            default: bad = 1'b1;
        endcase
        return {bad, c, v};
    endfunction

    function automatic string tag(logic [7:0] n, logic imm, logic [3:0] sc);
        if (sc > 4'd4) return "R11";
        if (sc == 4'd4) return "R6";
        if (sc == 4'd3 && n == 0 && imm) return "R7";
        if (n == 0) return "R8";
        if (sc == 4'd3) return "R5";
        if (sc == 4'd2) return (n >= 32) ? "R10" : "R4";
        if (n >= 32) return "R9";
        return (sc == 4'd0) ? "R2" : "R3";
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply at negedge, registered output appears after the next posedge
    task automatic run(logic [31:0] x, logic [7:0] n, logic imm, logic [3:0] sc, logic ci);
        logic [33:0] e;
        string t;
        operand = x; amt = n; amt_imm = imm; subcls = sc; carry_in = ci;
        e = model(x, n, imm, sc, ci);
        t = tag(n, imm, sc);
        @(posedge clk);
        @(negedge clk);
        check(t, "result", result, e[31:0]);
        check(t, "carry", {31'd0, carry_out}, {31'd0, e[32]});
        check({t, "/R12"}, "illegal", {31'd0, illegal}, {31'd0, e[33]});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        operand = 32'hDEAD_BEEF; subcls = 4'd3; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset clears outputs
        check("R12", "reset result", result, 32'd0);
        check("R12", "reset carry", {31'd0, carry_out}, 32'd0);
        check("R12", "reset illegal", {31'd0, illegal}, 32'd0);
        rst_n = 1'b1;

        // R1/R2/R3/R4: directed shifts
        run(32'h8000_0001, 8'd1, 1'b0, 4'd0, 1'b0);   // R2
        run(32'h8000_0001, 8'd31, 1'b1, 4'd0, 1'b0);  // R2
        run(32'h8000_0001, 8'd1, 1'b0, 4'd1, 1'b0);   // R3
        run(32'hF000_0010, 8'd5, 1'b0, 4'd2, 1'b0);   // R4
        run(32'h7000_0010, 8'd4, 1'b0, 4'd2, 1'b1);   // R4
        // R9: amounts 32 and above
        run(32'h0000_0001, 8'd32, 1'b0, 4'd0, 1'b0);
        run(32'h8000_0000, 8'd32, 1'b0, 4'd1, 1'b0);
        run(32'hFFFF_FFFF, 8'd33, 1'b0, 4'd0, 1'b1);
        run(32'hFFFF_FFFF, 8'd200, 1'b0, 4'd1, 1'b1);
        // R10: wide arithmetic shift
        run(32'h8000_0000, 8'd32, 1'b0, 4'd2, 1'b0);
        run(32'h7FFF_FFFF, 8'd255, 1'b0, 4'd2, 1'b1);
        // R5: rotate, including multiples of 32 from a register
        run(32'h1234_5678, 8'd8, 1'b0, 4'd3, 1'b0);
        run(32'h8000_0001, 8'd32, 1'b0, 4'd3, 1'b0);
        run(32'h0000_0001, 8'd64, 1'b1, 4'd3, 1'b1);
        // R7: ROR with zero amount, immediate vs register, back to back
        run(32'h0000_0003, 8'd0, 1'b1, 4'd3, 1'b1);
        run(32'h0000_0003, 8'd0, 1'b0, 4'd3, 1'b1);
        run(32'h0000_0002, 8'd0, 1'b1, 4'd3, 1'b0);
        // R6: dedicated carry rotate ignores amount
        run(32'hAAAA_AAAB, 8'd17, 1'b0, 4'd4, 1'b0);
        run(32'h5555_5554, 8'd0, 1'b1, 4'd4, 1'b1);
        // R8: zero amount pass-through
        run(32'hCAFE_F00D, 8'd0, 1'b1, 4'd0, 1'b1);
        run(32'hCAFE_F00D, 8'd0, 1'b0, 4'd2, 1'b0);
        // R11: reserved codes
        run(32'h0BAD_C0DE, 8'd3, 1'b0, 4'd5, 1'b1);
        run(32'h0BAD_C0DE, 8'd0, 1'b1, 4'd15, 1'b0);

        // Random mix (all requirements)
        for (int i = 0; i < 600; i++) begin
            logic [7:0] n;
            logic [3:0] sc;
            n  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 40));
            sc = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'($urandom_range(0, 4));
            run($urandom, n, 1'($urandom), sc, 1'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule